// File: doc/BRIEF.md
# Pulse-Count Programming Mode Selector

This block decides, at the end of a device reset, whether the device should start normally or enter on-board flash programming. If it should program, the block also picks the serial link that the boot loader will use. It watches a digital level that reports whether the programming voltage is present. While reset is held, the supply must first stay high long enough to arm the capture. After that, every qualified low pulse on it adds one to a counter. The final count names the transfer method.

When reset is released, the count is decoded into a one-hot method selection, a programming-mode flag and an error flag. A valid flag qualifies all three. They then stay frozen until reset is asserted again. Both inputs first pass through two-flop synchronizers. The block has no data stream and so no back-pressure; every pin is a plain level.

Top module: `pulse_mode_sel`

## Requirements
- R1: While `rst_n` is low, `sel_valid`, `prog_mode`, `sel_err` and `method_sel` are all 0.
- R2: Capture arms only once the synchronized `vpp_hi` has been high for at least 16 consecutive clocks during reset. If capture never armed, release reports normal start: `sel_valid`=1, `prog_mode`=0, `sel_err`=0, `method_sel`=0.
- R3: Once capture is armed, a pulse is counted when `vpp_hi` returns high after a low phase of at least 4 clocks. A low phase of 3 clocks or fewer is ignored.
- R4: Armed counts of 0, 1 and 2 select synchronous three-wire serial on link 0, 1 and 2. These set `method_sel` bit 0, 1 and 2 respectively, with `prog_mode`=1 and `sel_err`=0.
- R5: Armed counts of 8 and 9 select UART on link 0 and 1, setting `method_sel` bit 3 and bit 4. A count of 12 selects the software-driven three-wire mode on the timer pins, setting bit 5. In all three cases `prog_mode`=1 and `sel_err`=0.
- R6: Any other armed count sets `sel_err`=1 with `method_sel`=0 and `prog_mode`=1. The error stays set until the next reset, even if `vpp_hi` changes.
- R7: The pulse count saturates at 15, so a train of more than 15 pulses is reported as an error and never wraps into a legal code (28 pulses do not read as 12).
- R8: Results appear on the third rising clock edge after `rst_n` rises and not before. From then on, `sel_valid` stays 1 and all other outputs hold their values until `rst_n` falls, whatever `vpp_hi` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Device reset, active low; capture runs while it is low |
| vpp_hi | input | 1 | Programming voltage present (digital level, asynchronous) |
| method_sel | output | 6 | One-hot transfer method: bits 0-2 three-wire links 0-2, bits 3-4 UART links 0-1, bit 5 timer-pin three-wire |
| sel_valid | output | 1 | Outputs qualified; set at reset release, held until next reset |
| prog_mode | output | 1 | 1 = programming requested, 0 = normal start |
| sel_err | output | 1 | Illegal pulse count; sticky until next reset |

## Verification
`rst_n` rises just after a falling edge. The results are due on the third rising edge after that. The bench therefore samples at the falling edge after the second rising edge and expects `sel_valid` still 0. It samples again one clock later and expects the decoded results. Input changes on `vpp_hi` reach the counter two clocks late through the synchronizer. Each scenario therefore leaves at least four idle clocks after the last pulse before releasing reset. Low and arming windows are counted in whole clocks, which keeps the 3-versus-4 and 15-versus-16 boundaries exact. The clear on `rst_n` falling is asynchronous, so it is checked at the very next falling edge.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int METHOD_N = 6;

  // pulse count that selects each method slot of the one-hot output
  function automatic int method_code(input int slot);
    case (slot)
      0: method_code = 0;
      1: method_code = 1;
      2: method_code = 2;
      3: method_code = 8;
      4: method_code = 9;
      5: method_code = 12;
      default: method_code = -1;
    endcase
  endfunction
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pms_capture.sv
module pms_capture #(
  parameter int ARM_CLKS = 16,
  parameter int MIN_LOW  = 4,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             active,
  input  logic             line,
  output logic             armed,
  output logic [CNT_W-1:0] count
);
  localparam int HI_W = $clog2(ARM_CLKS + 1);
  localparam int LO_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [HI_W-1:0]  HI_TOP  = HI_W'(ARM_CLKS);
  localparam logic [HI_W-1:0]  HI_ARM  = HI_W'(ARM_CLKS - 1);
  localparam logic [LO_W-1:0]  LO_TOP  = LO_W'(MIN_LOW);

  logic [HI_W-1:0] hi_run;
  logic [LO_W-1:0] lo_run;

  // state is cleared whenever the device is out of reset
  always_ff @(posedge clk) begin
    if (!active) begin
      hi_run <= '0;
      lo_run <= '0;
      armed  <= 1'b0;
      count  <= '0;
    end else if (line) begin
      if (hi_run != HI_TOP) hi_run <= hi_run + 1'b1;
      if (hi_run == HI_ARM) armed <= 1'b1;
      if (armed && lo_run == LO_TOP && count != CNT_MAX) count <= count + 1'b1;
      lo_run <= '0;
    end else begin
      hi_run <= '0;
      if (armed && lo_run != LO_TOP) lo_run <= lo_run + 1'b1;
    end
  end
endmodule

// File: rtl/pms_decode.sv
module pms_decode
  import pms_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                armed,
  input  logic [CNT_W-1:0]    count,
  output logic [METHOD_N-1:0] sel,
  output logic                prog,
  output logic                err
);
  for (genvar m = 0; m < METHOD_N; m++) begin : g_slot
    assign sel[m] = armed && (int'(count) == method_code(m));
  end

  assign prog = armed;
  assign err  = armed && (sel == '0);
endmodule

// File: rtl/pulse_mode_sel.sv
module pulse_mode_sel
  import pms_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ARM_CLKS    = 16,
  parameter int MIN_LOW     = 4,
  parameter int CNT_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vpp_hi,
  output logic [METHOD_N-1:0] method_sel,
  output logic                sel_valid,
  output logic                prog_mode,
  output logic                sel_err
);
  logic rst_s, rst_s_d, vpp_s, release_now;
  logic armed;
  logic [CNT_W-1:0] count;
  logic [METHOD_N-1:0] dec_sel;
  logic dec_prog, dec_err;

  pms_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .clr_n(rst_n), .d(1'b1), .q(rst_s)
  );

  pms_sync #(.STAGES(SYNC_STAGES)) u_vpp_sync (
    .clk(clk), .clr_n(1'b1), .d(vpp_hi), .q(vpp_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s_d <= 1'b0;
    else        rst_s_d <= rst_s;
  end

  assign release_now = rst_s && !rst_s_d;

  pms_capture #(.ARM_CLKS(ARM_CLKS), .MIN_LOW(MIN_LOW), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .active(!rst_s), .line(vpp_s), .armed(armed), .count(count)
  );

  pms_decode #(.CNT_W(CNT_W)) u_dec (
    .armed(armed), .count(count), .sel(dec_sel), .prog(dec_prog), .err(dec_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      method_sel <= '0;
      sel_valid  <= 1'b0;
      prog_mode  <= 1'b0;
      sel_err    <= 1'b0;
    end else if (release_now) begin
      method_sel <= dec_sel;
      sel_valid  <= 1'b1;
      prog_mode  <= dec_prog;
      sel_err    <= dec_err;
    end
  end
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] sel,
  input logic       valid,
  input logic       prog,
  input logic       err
);
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  a_r8_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> ($stable(sel) && $stable(prog) && $stable(err)));

  a_r6_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (valid && prog && sel == 6'd0));

  a_r2_normal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !prog) |-> (sel == 6'd0 && !err));

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r5_prog_resolved: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && prog) |-> ($countones(sel) == 1 || err));
endmodule

bind pulse_mode_sel pms_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel(method_sel),
  .valid(sel_valid), .prog(prog_mode), .err(sel_err)
);

// File: tb/sim_pulse_mode_sel.sv
module sim_pulse_mode_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vpp_hi = 1'b0;
  logic [5:0] method_sel;
  logic sel_valid, prog_mode, sel_err;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_mode_sel u0 (
    .clk(clk), .rst_n(rst_n), .vpp_hi(vpp_hi),
    .method_sel(method_sel), .sel_valid(sel_valid),
    .prog_mode(prog_mode), .sel_err(sel_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    vpp_hi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic hold_high(input int n);
    vpp_hi = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    vpp_hi = 1'b0;
    repeat (lo) @(negedge clk);
    vpp_hi = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  // release at a falling edge; results due on third rising edge
  task automatic release_check(input string req, input int e_sel, input int e_prog, input int e_err);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R8", "valid before third edge", int'(sel_valid), 0);
    @(negedge clk);
    chk("R8", "valid at third edge", int'(sel_valid), 1);
    chk(req, "method_sel", int'(method_sel), e_sel);
    chk(req, "prog_mode", int'(prog_mode), e_prog);
    chk(req, "sel_err", int'(sel_err), e_err);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(sel_valid), 0);
    chk("R1", "sel in reset", int'(method_sel), 0);
    chk("R1", "prog in reset", int'(prog_mode), 0);
    chk("R1", "err in reset", int'(sel_err), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_never_raised();
    enter_reset();
    repeat (20) @(negedge clk);
    release_check("R2", 0, 0, 0);
  endtask

  task automatic t_arm_short();
    enter_reset();
    hold_high(15);
    vpp_hi = 1'b0;
    repeat (6) @(negedge clk);
    release_check("R2", 0, 0, 0);
  endtask

  task automatic t_arm_exact();
    enter_reset();
    hold_high(16);
    vpp_hi = 1'b0;
    repeat (6) @(negedge clk);
    release_check("R2", 1, 1, 0);
  endtask

  task automatic t_pulses(input string req, input int n, input int e_sel, input int e_err);
    enter_reset();
    hold_high(20);
    for (int i = 0; i < n; i++) pulse(5, 5);
    repeat (4) @(negedge clk);
    release_check(req, e_sel, 1, e_err);
  endtask

  task automatic t_glitch();
    enter_reset();
    hold_high(20);
    pulse(3, 5);
    pulse(4, 5);
    pulse(2, 3);
    pulse(6, 5);
    repeat (4) @(negedge clk);
    release_check("R3", 1 << 2, 1, 0);
  endtask

  task automatic t_hold(input string req, input int n, input int e_sel, input int e_err);
    t_pulses(req, n, e_sel, e_err);
    for (int i = 0; i < 10; i++) pulse(5, 5);
    chk("R8", "valid held", int'(sel_valid), 1);
    chk(req, "sel held after release", int'(method_sel), e_sel);
    chk(req, "err held after release", int'(sel_err), e_err);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "valid cleared", int'(sel_valid), 0);
    chk("R1", "sel cleared", int'(method_sel), 0);
    chk("R1", "err cleared", int'(sel_err), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    t_never_raised();
    t_arm_short();
    t_arm_exact();
    t_pulses("R4", 0, 1 << 0, 0);
    t_pulses("R4", 1, 1 << 1, 0);
    t_pulses("R4", 2, 1 << 2, 0);
    t_pulses("R5", 8, 1 << 3, 0);
    t_pulses("R5", 9, 1 << 4, 0);
    t_pulses("R5", 12, 1 << 5, 0);
    t_pulses("R6", 3, 0, 1);
    t_pulses("R6", 15, 0, 1);
    t_pulses("R7", 16, 0, 1);
    t_pulses("R7", 28, 0, 1);
    t_glitch();
    t_hold("R8", 9, 1 << 4, 0);
    t_hold("R6", 5, 0, 1);
    summary();
    $finish;
  end
endmodule